// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A transmitter turns characters of 5 to 9 data bits into frames on `txd`. A receiver recovers frames from `rxd` using 16x oversampling. One baud divisor sets the rate for both. Each frame has a start bit, the data least significant bit first, an optional parity bit and one stop bit.

The parity position is programmable. It can carry even parity, odd parity, a forced 0 or a forced 1, or it can be left out. In multidrop mode it carries an address marker instead. The transmitter can hold the line low as a break. The receiver reports parity errors, framing errors, overrun and incoming breaks as separate flags. A channel-mode input selects how the serial path is routed: normal, automatic echo, local loopback or remote loopback.

The host side is a plain write strobe and a read strobe with their data buses, a status vector, and an interrupt that is the OR of the enabled status bits. A request/acknowledge pair serves each direction, so a transfer engine can move characters without the host polling.

The transmitter runs the states TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP and TX_BREAK:
- TX_IDLE goes to TX_START on a baud tick when the holding register is full.
- TX_IDLE goes to TX_BREAK on a tick while a break is requested.
- TX_START goes to TX_DATA after one bit time.
- TX_DATA goes to TX_PAR after the last data bit, or to TX_STOP when there is no parity bit.
- TX_PAR goes to TX_STOP after one bit time.
- TX_STOP goes back to TX_IDLE after one bit time.
- TX_BREAK goes to TX_IDLE on a tick once the break request drops.

The receiver runs the states RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP and RX_BRKWAIT:
- RX_IDLE goes to RX_START on a tick that sees the line low.
- RX_START checks the line at the middle of the start bit. It returns to RX_IDLE if the line is high (a false start) and goes to RX_DATA if it is low.
- RX_DATA goes to RX_PAR or RX_STOP after the last data bit.
- RX_PAR goes to RX_STOP after one bit time.
- RX_STOP goes to RX_IDLE when it delivers a character, or to RX_BRKWAIT when the whole frame was zero.
- RX_BRKWAIT goes back to RX_IDLE on a tick that sees the line high.

Top module: `serial_port_core`

## Requirements
- R1: `char_len` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits; codes 5 to 7 act as 9 bits. A frame is a start bit (0), the data least significant bit first, an optional parity bit, then one stop bit (1). The idle line is 1.
- R2: `par_mode` codes select the parity bit: 0 gives even parity (the data bits plus the parity bit hold an even count of ones), 1 gives odd parity, 2 forces 0, 3 forces 1, 4 sends no parity bit, and 5 is multidrop. Codes 6 and 7 send no parity bit.
- R3: One bit lasts 16 times `baud_div` clock cycles; a divisor of 0 acts as 1. The receiver samples each bit at its middle.
- R4: Status bit 3 (parity error) and status bit 4 (framing error: the stop bit was sampled as 0) describe the character held in `rd_data`. They are updated each time a character is delivered.
- R5: Status bit 0 (receive ready) sets when a character is delivered and clears on a read. Status bit 2 (overrun) sets when a character is delivered while bit 0 is still set; the new character replaces the old one. A read clears bit 2.
- R6: While `send_break` is high and the transmitter is idle, `txd` is held at 0. When `send_break` drops, the line returns to 1 and normal frames follow.
- R7: A received frame that is all zeros, including the parity and stop positions, sets status bit 5 (break) and delivers no character. Bit 5 clears once the line is seen high again.
- R8: In multidrop mode (`par_mode` 5) the parity position carries `wr_addr_mark` on transmit. On receive, status bit 6 is the marker of the held character (1 = address), and no parity error is raised.
- R9: In channel mode 1 (echo), `txd` follows `rxd` and the receiver still gets the incoming frames.
- R10: In channel mode 2 (local loopback), `txd` stays at 1 and the transmitter output feeds the receiver.
- R11: In channel mode 3 (remote loopback), `txd` follows `rxd` and the receiver sees an idle line, so it delivers nothing.
- R12: `irq` is 1 exactly when `status & int_en` is nonzero. Status bit 1 is "transmit holding register empty".
- R13: `tx_dreq` is 1 while the transmit holding register is empty. `tx_dack` (like `wr_en`) loads `wr_data` into the holding register. A write while the register is full is ignored. `rx_dreq` equals receive ready, and `rx_dack` (like `rd_en`) consumes the character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Number of clock cycles per oversampling tick |
| char_len | input | 3 | Character length code |
| par_mode | input | 3 | Parity position mode |
| chan_mode | input | 2 | Channel routing: 0 normal, 1 echo, 2 local loop, 3 remote loop |
| send_break | input | 1 | Requests a break on the transmit line |
| wr_en | input | 1 | Host write strobe for the transmit holding register |
| wr_data | input | 9 | Character to transmit |
| wr_addr_mark | input | 1 | Multidrop marker sent with the written character |
| rd_en | input | 1 | Host read strobe; consumes the received character |
| rd_data | output | 9 | Last received character |
| status | output | 7 | {addr, break, frame err, parity err, overrun, tx empty, rx ready} |
| int_en | input | 7 | Per-bit enable mask for the interrupt |
| irq | output | 1 | Interrupt request |
| tx_dreq | output | 1 | Transmit transfer request |
| tx_dack | input | 1 | Transmit transfer acknowledge; loads `wr_data` |
| rx_dreq | output | 1 | Receive transfer request |
| rx_dack | input | 1 | Receive transfer acknowledge; consumes the character |
| txd | output | 1 | Serial transmit pin |
| rxd | input | 1 | Serial receive pin |

## Verification
The transmitter is tried with several combinations of length, parity mode and data:
- 8-bit even parity, to check the parity sense.
- 5-bit odd parity, to check the shortest length.
- 9-bit with no parity, where a wrong divisor would show as drift by the last bit.
- 7-bit forced one.
- Both multidrop marker values.

Each of these patterns separates a wrong bit order, a wrong parity sense or a miscounted length. The receiver is given frames that differ by one fault at a time: a clean frame, a wrong parity bit, a low stop bit, two frames with no read between them, and an all-zero line. Each flag must therefore rise alone. Each routing mode is then exercised with traffic on both pins, compared every clock against the expected pin relation, so that a mode that routes the wrong source is caught.

// File: rtl/sercore_pkg.sv
package sercore_pkg;

    localparam int          SUB_W     = 4;
    localparam logic [3:0]  SUB_LAST  = 4'd15;
    localparam logic [3:0]  SUB_HALF  = 4'd7;
    localparam int          CHAR_W    = 9;
    localparam int          ST_W      = 7;

    localparam int ST_RXRDY = 0;
    localparam int ST_TXEMP = 1;
    localparam int ST_OVR   = 2;
    localparam int ST_PERR  = 3;
    localparam int ST_FERR  = 4;
    localparam int ST_BRK   = 5;
    localparam int ST_ADDR  = 6;

    localparam logic [2:0] PAR_EVEN  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_ZERO  = 3'd2;
    localparam logic [2:0] PAR_ONE   = 3'd3;
    localparam logic [2:0] PAR_NONE  = 3'd4;
    localparam logic [2:0] PAR_MDROP = 3'd5;

    localparam logic [1:0] CH_NORMAL = 2'd0;
    localparam logic [1:0] CH_ECHO   = 2'd1;
    localparam logic [1:0] CH_LLOOP  = 2'd2;
    localparam logic [1:0] CH_RLOOP  = 2'd3;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BREAK
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_BRKWAIT
    } rx_state_t;

    function automatic logic [3:0] char_bits(input logic [2:0] code);
        return (code > 3'd4) ? 4'd9 : ({1'b0, code} + 4'd5);
    endfunction

    function automatic logic [CHAR_W-1:0] char_mask(input logic [2:0] code);
        return 9'h1FF >> (4'd9 - char_bits(code));
    endfunction

    function automatic logic parity_used(input logic [2:0] mode);
        return (mode <= PAR_ONE) || (mode == PAR_MDROP);
    endfunction

    function automatic logic frame_parity(input logic [2:0] mode,
                                          input logic [CHAR_W-1:0] d,
                                          input logic mark);
        case (mode)
            PAR_EVEN:  return ^d;
            PAR_ODD:   return ~(^d);
            PAR_ONE:   return 1'b1;
            PAR_MDROP: return mark;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sercore_baud.sv
module sercore_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= (div == '0) ? '0 : div - DIV_W'(1);
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - DIV_W'(1);
            tick <= 1'b0;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(div) > DIV_W'(1)) |=> !tick); // R3

endmodule

// File: rtl/sercore_tx.sv
module sercore_tx
    import sercore_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [2:0]        len_code,
    input  logic [2:0]        par_mode,
    input  logic              send_break,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    input  logic              load_mark,
    output logic              line,
    output logic              hold_empty
);
    tx_state_t         st, nxt;
    logic [SUB_W-1:0]  sub;
    logic [3:0]        bitn;
    logic [3:0]        nbits;
    logic [CHAR_W-1:0] shreg, hold, masked;
    logic              hold_mark, hold_full, par_q, bit_end;

    assign nbits      = char_bits(len_code);
    assign masked     = hold & char_mask(len_code);
    assign bit_end    = tick && (sub == SUB_LAST);
    assign hold_empty = !hold_full;

    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE: begin
                if (tick && send_break)     nxt = TX_BREAK;
                else if (tick && hold_full) nxt = TX_START;
            end
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bitn == nbits - 4'd1)
                          nxt = parity_used(par_mode) ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end) nxt = TX_IDLE;
            TX_BREAK: if (tick && !send_break) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            hold      <= '0;
            hold_mark <= 1'b0;
            hold_full <= 1'b0;
            par_q     <= 1'b0;
        end else begin
            if (load && !hold_full) begin
                hold      <= load_data;
                hold_mark <= load_mark;
                hold_full <= 1'b1;
            end
            if (st == TX_IDLE && nxt == TX_START) begin
                shreg     <= masked;
                par_q     <= frame_parity(par_mode, masked, hold_mark);
                bitn      <= '0;
                sub       <= '0;
                hold_full <= 1'b0;
            end else if (tick) begin
                if (st == TX_IDLE || st == TX_BREAK) sub <= '0;
                else                                 sub <= sub + SUB_W'(1);
                if (st == TX_DATA && sub == SUB_LAST) begin
                    shreg <= shreg >> 1;
                    bitn  <= bitn + 4'd1;
                end
            end
        end
    end

    always_comb begin
        unique case (st)
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg[0];
            TX_PAR:   line = par_q;
            TX_BREAK: line = 1'b0;
            default:  line = 1'b1;
        endcase
    end

    AST_TX_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !(tick && st == TX_IDLE && !send_break)) |=> hold_full); // R13

    AST_TX_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_DATA && $stable(len_code)) |-> (bitn < nbits)); // R1

endmodule

// File: rtl/sercore_rx.sv
module sercore_rx
    import sercore_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [2:0]        len_code,
    input  logic [2:0]        par_mode,
    input  logic              consume,
    output logic [CHAR_W-1:0] data,
    output logic              ready,
    output logic              ovr,
    output logic              perr,
    output logic              ferr,
    output logic              brk,
    output logic              addr
);
    rx_state_t         st, nxt;
    logic [SUB_W-1:0]  sub;
    logic [3:0]        bitn;
    logic [3:0]        nbits;
    logic [CHAR_W-1:0] shreg;
    logic              par_s, bit_mid, start_mid, all_zero, deliver, bad_par;

    assign nbits     = char_bits(len_code);
    assign bit_mid   = tick && (sub == SUB_LAST);
    assign start_mid = tick && (sub == SUB_HALF);
    assign all_zero  = (shreg == '0) && !(parity_used(par_mode) && par_s) && !rxd;
    assign deliver   = (st == RX_STOP) && bit_mid && !all_zero;
    assign bad_par   = parity_used(par_mode) && (par_mode != PAR_MDROP)
                       && (par_s != frame_parity(par_mode, shreg, 1'b0));

    always_comb begin
        nxt = st;
        unique case (st)
            RX_IDLE:    if (tick && !rxd) nxt = RX_START;
            RX_START:   if (start_mid) nxt = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:    if (bit_mid && bitn == nbits - 4'd1)
                            nxt = parity_used(par_mode) ? RX_PAR : RX_STOP;
            RX_PAR:     if (bit_mid) nxt = RX_STOP;
            RX_STOP:    if (bit_mid) nxt = all_zero ? RX_BRKWAIT : RX_IDLE;
            RX_BRKWAIT: if (tick && rxd) nxt = RX_IDLE;
            default:    nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            par_s <= 1'b0;
        end else if (tick) begin
            if (st == RX_IDLE || st == RX_BRKWAIT || (st == RX_START && sub == SUB_HALF))
                sub <= '0;
            else
                sub <= sub + SUB_W'(1);
            if (st == RX_START && sub == SUB_HALF) begin
                shreg <= '0;
                bitn  <= '0;
            end
            if (st == RX_DATA && sub == SUB_LAST) begin
                shreg[bitn] <= rxd;
                bitn        <= bitn + 4'd1;
            end
            if (st == RX_PAR && sub == SUB_LAST) par_s <= rxd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            brk   <= 1'b0;
            addr  <= 1'b0;
        end else begin
            if (deliver) begin
                data  <= shreg;
                ferr  <= !rxd;
                perr  <= bad_par;
                addr  <= (par_mode == PAR_MDROP) && par_s;
                ready <= 1'b1;
                if (ready && !consume) ovr <= 1'b1;
            end else if (consume) begin
                ready <= 1'b0;
                ovr   <= 1'b0;
            end
            if (st == RX_STOP && bit_mid && all_zero) brk <= 1'b1;
            else if (st == RX_BRKWAIT && tick && rxd)  brk <= 1'b0;
        end
    end

    AST_RX_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(ready)); // R5

    AST_RX_BRK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> $stable(data)); // R7

endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
    import sercore_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [2:0]        char_len,
    input  logic [2:0]        par_mode,
    input  logic [1:0]        chan_mode,
    input  logic              send_break,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_addr_mark,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_data,
    output logic [ST_W-1:0]   status,
    input  logic [ST_W-1:0]   int_en,
    output logic              irq,
    output logic              tx_dreq,
    input  logic              tx_dack,
    output logic              rx_dreq,
    input  logic              rx_dack,
    output logic              txd,
    input  logic              rxd
);
    logic                   tick, tx_line, core_rx, hold_empty;
    logic                   rdy, ovr, perr, ferr, brk, addr;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_pin_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
    assign rx_pin_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        unique case (chan_mode)
            CH_ECHO:  begin txd = rxd;     core_rx = rx_pin_s; end
            CH_LLOOP: begin txd = 1'b1;    core_rx = tx_line;  end
            CH_RLOOP: begin txd = rxd;     core_rx = 1'b1;     end
            default:  begin txd = tx_line; core_rx = rx_pin_s; end
        endcase
    end

    sercore_baud #(.DIV_W(DIV_W)) i_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    sercore_tx i_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .len_code(char_len), .par_mode(par_mode), .send_break(send_break),
        .load(wr_en | tx_dack), .load_data(wr_data), .load_mark(wr_addr_mark),
        .line(tx_line), .hold_empty(hold_empty)
    );

    sercore_rx i_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(core_rx),
        .len_code(char_len), .par_mode(par_mode), .consume(rd_en | rx_dack),
        .data(rd_data), .ready(rdy), .ovr(ovr), .perr(perr), .ferr(ferr),
        .brk(brk), .addr(addr)
    );

    always_comb begin
        status           = '0;
        status[ST_RXRDY] = rdy;
        status[ST_TXEMP] = hold_empty;
        status[ST_OVR]   = ovr;
        status[ST_PERR]  = perr;
        status[ST_FERR]  = ferr;
        status[ST_BRK]   = brk;
        status[ST_ADDR]  = addr;
    end

    assign irq     = |(status & int_en);
    assign tx_dreq = hold_empty;
    assign rx_dreq = rdy;

endmodule

// File: tb/test_serial_port_core.sv
module test_serial_port_core;
    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'(DIV);
    logic [2:0]  char_len = 3'd3;
    logic [2:0]  par_mode = 3'd4;
    logic [1:0]  chan_mode = 2'd0;
    logic        send_break = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        wr_addr_mark = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_data;
    logic [6:0]  status;
    logic [6:0]  int_en = '0;
    logic        irq, tx_dreq, rx_dreq, txd;
    logic        tx_dack = 1'b0;
    logic        rx_dack = 1'b0;
    logic        rxd = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_port_core i_serial_port_core (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .char_len(char_len),
        .par_mode(par_mode), .chan_mode(chan_mode), .send_break(send_break),
        .wr_en(wr_en), .wr_data(wr_data), .wr_addr_mark(wr_addr_mark),
        .rd_en(rd_en), .rd_data(rd_data), .status(status), .int_en(int_en),
        .irq(irq), .tx_dreq(tx_dreq), .tx_dack(tx_dack), .rx_dreq(rx_dreq),
        .rx_dack(rx_dack), .txd(txd), .rxd(rxd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit calc_par(input int pk, input logic [8:0] d, input int nb, input bit mark);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        case (pk)
            0:       return bit'(ones % 2);
            1:       return !bit'(ones % 2);
            3:       return 1'b1;
            5:       return mark;
            default: return 1'b0;
        endcase
    endfunction

    // per-clock reference for the routing modes and the interrupt
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (chan_mode == 2'd1) chk("R9", "echo txd", txd, rxd);
            if (chan_mode == 2'd3) chk("R11", "remote txd", txd, rxd);
            if (chan_mode == 2'd2) chk("R10", "local txd idle", txd, 1);
            chk("R12", "irq", irq, int'(|(status & int_en)));
        end
    end

    task automatic host_write(input logic [8:0] d, input bit mark);
        @(negedge clk); wr_data = d; wr_addr_mark = mark; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic expect_tx(input string req, input logic [8:0] d, input int nb,
                             input int pk, input bit mark);
        bit q[$];
        int w;
        q.push_back(1'b0);
        for (int i = 0; i < nb; i++) q.push_back(d[i]);
        if (pk <= 3 || pk == 5) q.push_back(calc_par(pk, d, nb, mark));
        q.push_back(1'b1);
        w = 0;
        while (txd !== 1'b0 && w < 400) begin @(negedge clk); w++; end
        chk(req, "start bit seen", int'(w < 400), 1);
        repeat (BIT / 2) @(negedge clk);
        foreach (q[i]) begin
            chk(req, $sformatf("tx bit %0d of %03h", i, d), txd, q[i]);
            repeat (BIT) @(negedge clk);
        end
    endtask

    task automatic send_rx(input logic [8:0] d, input int nb, input bit has_par,
                           input bit pb, input bit stopv);
        rxd = 1'b0; repeat (BIT) @(negedge clk);
        for (int i = 0; i < nb; i++) begin rxd = d[i]; repeat (BIT) @(negedge clk); end
        if (has_par) begin rxd = pb; repeat (BIT) @(negedge clk); end
        rxd = stopv;
        if (stopv) repeat (BIT) @(negedge clk);
        else       repeat (BIT / 2 + 2 * DIV + 4) @(negedge clk);
        rxd = 1'b1; repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "tx_dreq after reset", tx_dreq, 1);
        chk("R13", "rx_dreq after reset", rx_dreq, 0);
        chk("R1", "txd idle after reset", txd, 1);
        chk("R12", "status after reset", status, 7'h02);
        chk("R12", "irq after reset", irq, 0);

        // transmitter patterns
        char_len = 3'd3; par_mode = 3'd0;
        host_write(9'h0A5, 1'b0); expect_tx("R2", 9'h0A5, 8, 0, 1'b0);
        char_len = 3'd0; par_mode = 3'd1;
        host_write(9'h013, 1'b0); expect_tx("R1", 9'h013, 5, 1, 1'b0);
        char_len = 3'd4; par_mode = 3'd4;
        host_write(9'h1A5, 1'b0); expect_tx("R3", 9'h1A5, 9, 4, 1'b0);
        char_len = 3'd2; par_mode = 3'd3;
        host_write(9'h040, 1'b0); expect_tx("R2", 9'h040, 7, 3, 1'b0);
        char_len = 3'd3; par_mode = 3'd5;
        host_write(9'h033, 1'b1); expect_tx("R8", 9'h033, 8, 5, 1'b1);
        host_write(9'h034, 1'b0); expect_tx("R8", 9'h034, 8, 5, 1'b0);

        // receiver: clean, parity error, framing error
        par_mode = 3'd0;
        send_rx(9'h05C, 8, 1'b1, calc_par(0, 9'h05C, 8, 1'b0), 1'b1);
        chk("R1", "rx ready", rx_dreq, 1);
        chk("R1", "rx data", rd_data, 9'h05C);
        chk("R4", "no parity error", status[3], 0);
        chk("R4", "no framing error", status[4], 0);
        host_read();
        chk("R5", "ready cleared by read", status[0], 0);
        send_rx(9'h05C, 8, 1'b1, !calc_par(0, 9'h05C, 8, 1'b0), 1'b1);
        chk("R4", "parity error flagged", status[3], 1);
        host_read();
        send_rx(9'h03A, 8, 1'b1, calc_par(0, 9'h03A, 8, 1'b0), 1'b0);
        chk("R4", "framing error flagged", status[4], 1);
        chk("R4", "framing error data", rd_data, 9'h03A);
        chk("R4", "parity ok with framing error", status[3], 0);
        host_read();
        send_rx(9'h03B, 8, 1'b1, calc_par(0, 9'h03B, 8, 1'b0), 1'b1);
        chk("R4", "framing error cleared by next char", status[4], 0);
        host_read();

        // overrun
        par_mode = 3'd4;
        send_rx(9'h011, 8, 1'b0, 1'b0, 1'b1);
        chk("R5", "no overrun on first", status[2], 0);
        send_rx(9'h022, 8, 1'b0, 1'b0, 1'b1);
        chk("R5", "overrun set", status[2], 1);
        chk("R5", "newer char kept", rd_data, 9'h022);
        host_read();
        chk("R5", "overrun cleared by read", status[2], 0);
        chk("R5", "ready cleared", status[0], 0);

        // break detection
        rxd = 1'b0; repeat (12 * BIT) @(negedge clk);
        chk("R7", "break flagged", status[5], 1);
        chk("R7", "break delivers nothing", status[0], 0);
        rxd = 1'b1; repeat (2 * BIT) @(negedge clk);
        chk("R7", "break cleared after line high", status[5], 0);
        chk("R7", "still nothing delivered", status[0], 0);

        // multidrop receive
        par_mode = 3'd5;
        send_rx(9'h007, 8, 1'b1, 1'b1, 1'b1);
        chk("R8", "address marker seen", status[6], 1);
        chk("R8", "no parity error in multidrop", status[3], 0);
        host_read();
        send_rx(9'h008, 8, 1'b1, 1'b0, 1'b1);
        chk("R8", "data marker seen", status[6], 0);
        chk("R8", "data char", rd_data, 9'h008);
        host_read();

        // interrupt mask
        par_mode = 3'd4;
        int_en = 7'h01;
        @(negedge clk);
        chk("R12", "irq idle with rx mask", irq, 0);
        send_rx(9'h055, 8, 1'b0, 1'b0, 1'b1);
        chk("R12", "irq on rx ready", irq, 1);
        host_read();
        chk("R12", "irq dropped after read", irq, 0);
        int_en = 7'h02;
        @(negedge clk);
        chk("R12", "irq on tx empty", irq, 1);
        int_en = 7'h00;

        // request/acknowledge channels
        @(negedge clk); wr_data = 9'h06E; wr_addr_mark = 1'b0; tx_dack = 1'b1;
        @(negedge clk); tx_dack = 1'b0;
        chk("R13", "tx_dreq drops after ack", tx_dreq, 0);
        expect_tx("R13", 9'h06E, 8, 4, 1'b0);
        chk("R13", "tx_dreq back", tx_dreq, 1);
        send_rx(9'h077, 8, 1'b0, 1'b0, 1'b1);
        chk("R13", "rx_dreq raised", rx_dreq, 1);
        @(negedge clk); rx_dack = 1'b1;
        @(negedge clk); rx_dack = 1'b0;
        chk("R13", "rx_dreq cleared by ack", rx_dreq, 0);

        // echo
        chan_mode = 2'd1;
        send_rx(9'h03C, 8, 1'b0, 1'b0, 1'b1);
        chk("R9", "echo still receives", rd_data, 9'h03C);
        chk("R9", "echo ready", rx_dreq, 1);
        host_read();

        // local loopback
        chan_mode = 2'd2;
        host_write(9'h096, 1'b0);
        repeat (12 * BIT) @(negedge clk);
        chk("R10", "loopback ready", rx_dreq, 1);
        chk("R10", "loopback data", rd_data, 9'h096);
        host_read();

        // remote loopback
        chan_mode = 2'd3;
        send_rx(9'h081, 8, 1'b0, 1'b0, 1'b1);
        chk("R11", "receiver isolated", rx_dreq, 0);
        chan_mode = 2'd0;
        repeat (4) @(negedge clk);

        // break generation
        send_break = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk("R6", "txd held low", txd, 0);
        send_break = 1'b0;
        repeat (BIT) @(negedge clk);
        chk("R6", "txd high after break", txd, 1);
        host_write(9'h0C3, 1'b0); expect_tx("R6", 9'h0C3, 8, 4, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL all watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule